// File: doc/BRIEF.md
# Processor Status Flag Unit

This block holds the 8-bit status word of a small 8-bit CPU. Each cycle the instruction decoder may raise one or more strobes. An add or subtract updates the zero, auxiliary-carry and carry flags from the ALU result and its carries. A rotate loads the bit shifted out into carry. A bit-operation instruction writes a single bit into carry, so carry serves as a one-bit accumulator. Further strobes enable or disable interrupts, pick one of four register banks, load the whole word at once (as a return from interrupt does) or mark an interrupt as acknowledged.

The block also gates maskable interrupts. A pending request comes with a mask bit and a high/low priority tag. The block accepts it only when the global enable bit is set, the request is unmasked, and either the request is high priority or the in-service priority bit is set. The accept output is combinational. The status word and the bank index are registered.

Top module: `psw_unit`

## Requirements
- R1: A synchronous active-high reset sets the status word to 0x02: interrupts disabled, bank 0 selected, ISP set, all other flags cleared.
- R2: The bit layout from bit 7 down to bit 0 is IE, Z, RBS1, AC, RBS0, unused, ISP, CY. Bit 2 always reads 0. The bank output equals {bit 5, bit 3}.
- R3: An EI strobe sets IE on the next edge and a DI strobe clears it. When both are raised in the same cycle, DI wins.
- R4: `int_accept` = `irq_pend` & ~`irq_mask` & IE & (`irq_hi` | ISP) within the same cycle. `irq_mask`=1 means the source is masked. `irq_hi`=1 means high priority.
- R5: An `int_ack` strobe clears IE on the next edge, and this overrides EI in the same cycle. If `irq_hi` is 1 during the acknowledge, ISP is also cleared. If it is 0, ISP is left unchanged.
- R6: On `op_addsub`, Z becomes 1 exactly when `alu_result` is all zeros.
- R7: On `op_addsub`, AC takes `alu_c3` (the carry out of or borrow into bit 3).
- R8: CY takes `alu_c7` on `op_addsub`, the shifted-out bit `alu_c7` on `op_rotate`, and `bit_in` on `op_bitop`. When several of these strobes are raised together, the priority is addsub, then rotate, then bitop.
- R9: An `op_selbank` strobe writes `bank_in` into RBS1:RBS0 on the next edge.
- R10: An `op_load` strobe writes `load_word` with bit 2 forced to 0. It overrides every other flag update in that cycle.
- R11: A flag that no strobe in the cycle targets keeps its value. For example, rotate and bitop leave Z and AC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_result | input | 8 | ALU result for zero detection |
| alu_c7 | input | 1 | Carry out of bit 7, or the bit shifted out on a rotate |
| alu_c3 | input | 1 | Carry or borrow at bit 3 |
| bit_in | input | 1 | Bit value written into CY by a bit-operation instruction |
| op_addsub | input | 1 | Add/subtract flag update strobe |
| op_rotate | input | 1 | Rotate strobe |
| op_bitop | input | 1 | Bit-operation write-to-carry strobe |
| op_ei | input | 1 | Enable interrupts |
| op_di | input | 1 | Disable interrupts |
| op_selbank | input | 1 | Register bank select strobe |
| bank_in | input | 2 | Bank number for select |
| op_load | input | 1 | Full status-word load strobe |
| load_word | input | 8 | Word to load |
| int_ack | input | 1 | Interrupt acknowledge strobe |
| irq_pend | input | 1 | Maskable request pending |
| irq_hi | input | 1 | Request priority, 1 = high |
| irq_mask | input | 1 | Source mask, 1 = masked |
| psw | output | 8 | Registered status word |
| bank | output | 2 | Selected register bank |
| int_accept | output | 1 | Request accepted this cycle |

## Verification
The bench first raises requests while IE is 0, then low-priority requests with ISP cleared. A design that lets either through would accept interrupts that must stay blocked. It also applies conflicting strobes in the same cycle: EI with DI, EI with acknowledge, addsub with bitop, and a full load together with flag updates. A wrong priority shows up as a flipped IE or CY, or as a loaded word corrupted by a flag update. Acknowledges at both priorities check that ISP is cleared only by high-priority ones. Rotate and bitop steps confirm that Z and AC keep their values, and loading 0xFF confirms that the unused bit stays 0.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W  = 8;
  localparam int BANK_W = 2;
  localparam logic [PSW_W-1:0] PSW_RST   = 8'h02;
  localparam logic [PSW_W-1:0] LOAD_MASK = 8'hFB;

  typedef struct packed {
    logic ie;
    logic z;
    logic rb1;
    logic ac;
    logic rb0;
    logic nu;
    logic isp;
    logic cy;
  } psw_t;
endpackage

// File: rtl/psw_arith_flags.sv
module psw_arith_flags #(
  parameter int DATA_W = 8
) (
  input  logic              z_q,
  input  logic              ac_q,
  input  logic              cy_q,
  input  logic [DATA_W-1:0] result,
  input  logic              c7,
  input  logic              c3,
  input  logic              bit_in,
  input  logic              do_addsub,
  input  logic              do_rotate,
  input  logic              do_bitop,
  output logic              z_d,
  output logic              ac_d,
  output logic              cy_d
);
  logic is_zero;
  assign is_zero = (result == '0);

  always_comb begin
    z_d  = z_q;
    ac_d = ac_q;
    cy_d = cy_q;
    if (do_addsub) begin
      z_d  = is_zero;
      ac_d = c3;
      cy_d = c7;
    end else if (do_rotate) begin
      cy_d = c7;
    end else if (do_bitop) begin
      cy_d = bit_in;
    end
  end
endmodule

// File: rtl/psw_bank_sel.sv
module psw_bank_sel #(
  parameter int BANK_W = 2
) (
  input  logic              do_sel,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [BANK_W-1:0] bank_q,
  output logic [BANK_W-1:0] bank_d
);
  always_comb begin
    bank_d = bank_q;
    if (do_sel) bank_d = bank_in;
  end
endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate (
  input  logic ie_q,
  input  logic isp_q,
  input  logic pend,
  input  logic hi,
  input  logic mask,
  input  logic do_ei,
  input  logic do_di,
  input  logic do_ack,
  output logic accept,
  output logic ie_d,
  output logic isp_d
);
  assign accept = pend & ~mask & ie_q & (hi | isp_q);

  always_comb begin
    ie_d  = ie_q;
    isp_d = isp_q;
    if (do_ack || do_di) ie_d = 1'b0;
    else if (do_ei)      ie_d = 1'b1;
    if (do_ack && hi)    isp_d = 1'b0;
  end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_c7,
  input  logic              alu_c3,
  input  logic              bit_in,
  input  logic              op_addsub,
  input  logic              op_rotate,
  input  logic              op_bitop,
  input  logic              op_ei,
  input  logic              op_di,
  input  logic              op_selbank,
  input  logic [BANK_W-1:0] bank_in,
  input  logic              op_load,
  input  logic [PSW_W-1:0]  load_word,
  input  logic              int_ack,
  input  logic              irq_pend,
  input  logic              irq_hi,
  input  logic              irq_mask,
  output logic [PSW_W-1:0]  psw,
  output logic [BANK_W-1:0] bank,
  output logic              int_accept
);
  psw_t              psw_q;
  psw_t              psw_n;
  logic              z_d, ac_d, cy_d, ie_d, isp_d;
  logic [BANK_W-1:0] bank_d;

  psw_arith_flags #(.DATA_W(DATA_W)) u_arith (
    .z_q(psw_q.z), .ac_q(psw_q.ac), .cy_q(psw_q.cy),
    .result(alu_result), .c7(alu_c7), .c3(alu_c3), .bit_in(bit_in),
    .do_addsub(op_addsub), .do_rotate(op_rotate), .do_bitop(op_bitop),
    .z_d(z_d), .ac_d(ac_d), .cy_d(cy_d)
  );

  psw_bank_sel #(.BANK_W(BANK_W)) u_bank (
    .do_sel(op_selbank), .bank_in(bank_in),
    .bank_q({psw_q.rb1, psw_q.rb0}), .bank_d(bank_d)
  );

  psw_irq_gate u_gate (
    .ie_q(psw_q.ie), .isp_q(psw_q.isp),
    .pend(irq_pend), .hi(irq_hi), .mask(irq_mask),
    .do_ei(op_ei), .do_di(op_di), .do_ack(int_ack),
    .accept(int_accept), .ie_d(ie_d), .isp_d(isp_d)
  );

  always_comb begin
    if (op_load) begin
      psw_n = psw_t'(load_word & LOAD_MASK);
    end else begin
      psw_n.ie  = ie_d;
      psw_n.z   = z_d;
      psw_n.rb1 = bank_d[1];
      psw_n.ac  = ac_d;
      psw_n.rb0 = bank_d[0];
      psw_n.nu  = 1'b0;
      psw_n.isp = isp_d;
      psw_n.cy  = cy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) psw_q <= psw_t'(PSW_RST);
    else     psw_q <= psw_n;
  end

  assign psw  = psw_q;
  assign bank = {psw_q.rb1, psw_q.rb0};
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] alu_result,
  input logic       alu_c3,
  input logic       op_addsub,
  input logic       op_ei,
  input logic       op_di,
  input logic       op_load,
  input logic [7:0] load_word,
  input logic       int_ack,
  input logic       irq_hi,
  input logic       irq_pend,
  input logic       irq_mask,
  input logic [7:0] psw,
  input logic [1:0] bank,
  input logic       int_accept
);
  p_accept_needs_ie_r4: assert property (@(posedge clk) disable iff (rst)
    int_accept |-> (psw[7] && irq_pend && !irq_mask));

  p_low_needs_isp_r4: assert property (@(posedge clk) disable iff (rst)
    (int_accept && !irq_hi) |-> psw[1]);

  p_ack_clears_ie_r5: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !op_load) |=> !psw[7]);

  p_di_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (op_di && op_ei && !op_load) |=> !psw[7]);

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (op_addsub && !op_load) |=> (psw[6] == ($past(alu_result) == 8'h00)));

  p_aux_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (op_addsub && !op_load) |=> (psw[4] == $past(alu_c3)));

  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    op_load |=> (psw == ($past(load_word) & 8'hFB)));

  p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (!psw[2] && (bank == {psw[5], psw[3]})));
endmodule

bind psw_unit psw_unit_chk u_chk (
  .clk(clk), .rst(rst), .alu_result(alu_result), .alu_c3(alu_c3),
  .op_addsub(op_addsub), .op_ei(op_ei), .op_di(op_di), .op_load(op_load),
  .load_word(load_word), .int_ack(int_ack), .irq_hi(irq_hi),
  .irq_pend(irq_pend), .irq_mask(irq_mask), .psw(psw), .bank(bank),
  .int_accept(int_accept)
);

// File: tb/psw_unit_tb_top.sv
module psw_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] alu_result = 8'h00;
  logic alu_c7 = 0, alu_c3 = 0, bit_in = 0;
  logic op_addsub = 0, op_rotate = 0, op_bitop = 0, op_ei = 0, op_di = 0;
  logic op_selbank = 0, op_load = 0, int_ack = 0;
  logic [1:0] bank_in = 2'd0;
  logic [7:0] load_word = 8'h00;
  logic irq_pend = 0, irq_hi = 0, irq_mask = 0;
  logic [7:0] psw;
  logic [1:0] bank;
  logic int_accept;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] m_psw = 8'h00;
  bit         m_known = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_unit dut_i (
    .clk(clk), .rst(rst), .alu_result(alu_result), .alu_c7(alu_c7),
    .alu_c3(alu_c3), .bit_in(bit_in), .op_addsub(op_addsub),
    .op_rotate(op_rotate), .op_bitop(op_bitop), .op_ei(op_ei), .op_di(op_di),
    .op_selbank(op_selbank), .bank_in(bank_in), .op_load(op_load),
    .load_word(load_word), .int_ack(int_ack), .irq_pend(irq_pend),
    .irq_hi(irq_hi), .irq_mask(irq_mask), .psw(psw), .bank(bank),
    .int_accept(int_accept)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: one edge after each driven cycle, compare against the queued prediction
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (psw !== e) begin
        errors++;
        $display("FAIL %s psw: actual %02h expected %02h", t, psw, e);
      end
      checks++;
      if (bank !== {e[5], e[3]}) begin
        errors++;
        $display("FAIL R2 bank: actual %0d expected %0d", bank, {e[5], e[3]});
      end
    end
  end

  // Driver: check accept for current inputs, predict next word, run one cycle
  task automatic step(string tag);
    logic [7:0] n;
    logic acc;
    #1;
    if (m_known && !rst) begin
      acc = irq_pend & ~irq_mask & m_psw[7] & (irq_hi | m_psw[1]);
      checks++;
      if (int_accept !== acc) begin
        errors++;
        $display("FAIL R4 (%s) int_accept: actual %b expected %b", tag, int_accept, acc);
      end
    end
    n = m_psw;
    if (rst) n = 8'h02;
    else if (op_load) n = load_word & 8'hFB;
    else begin
      if (int_ack || op_di) n[7] = 1'b0;
      else if (op_ei) n[7] = 1'b1;
      if (int_ack && irq_hi) n[1] = 1'b0;
      if (op_addsub) begin
        n[6] = (alu_result == 8'h00);
        n[4] = alu_c3;
        n[0] = alu_c7;
      end else if (op_rotate) n[0] = alu_c7;
      else if (op_bitop) n[0] = bit_in;
      if (op_selbank) begin n[5] = bank_in[1]; n[3] = bank_in[0]; end
    end
    exp_q.push_back(n);
    tag_q.push_back(tag);
    m_psw = n;
    m_known = 1;
    @(negedge clk);
    op_addsub = 0; op_rotate = 0; op_bitop = 0; op_ei = 0; op_di = 0;
    op_selbank = 0; op_load = 0; int_ack = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    @(negedge clk);
    rst = 1; step("R1 reset");
    step("R1 reset hold");
    rst = 0;
    irq_pend = 1; irq_hi = 1; irq_mask = 0;
    step("R4 IE=0 blocks high request");
    op_ei = 1; step("R3 EI sets IE");
    irq_hi = 0; step("R4 low accepted with ISP=1");
    irq_mask = 1; step("R4 masked request blocked");
    irq_mask = 0; int_ack = 1; step("R5 low ack keeps ISP");
    op_ei = 1; step("R3 EI again");
    irq_hi = 1; int_ack = 1; step("R5 high ack clears ISP");
    op_ei = 1; step("R3 EI with ISP=0");
    irq_hi = 0; step("R4 low blocked when ISP=0");
    irq_hi = 1; step("R4 high accepted when ISP=0");
    op_ei = 1; op_di = 1; step("R3 DI wins over EI");
    op_ei = 1; step("R3 EI");
    op_ei = 1; int_ack = 1; irq_hi = 0; step("R5 ack wins over EI");
    irq_pend = 0;
    alu_result = 8'h00; alu_c7 = 1; alu_c3 = 1; op_addsub = 1;
    step("R6 R7 R8 zero result with carries");
    op_rotate = 1; alu_c7 = 0; alu_result = 8'h33; alu_c3 = 0;
    step("R11 rotate keeps Z AC, R8 CY=shift-out");
    op_bitop = 1; bit_in = 1; step("R8 bitop writes CY");
    alu_result = 8'h5A; alu_c7 = 0; alu_c3 = 0; op_addsub = 1;
    op_bitop = 1; bit_in = 1; step("R8 addsub beats bitop");
    op_rotate = 1; alu_c7 = 1; op_bitop = 1; bit_in = 0;
    step("R8 rotate beats bitop");
    op_selbank = 1; bank_in = 2'd2; step("R9 bank 2");
    op_selbank = 1; bank_in = 2'd1; step("R9 bank 1");
    op_selbank = 1; bank_in = 2'd3; step("R9 bank 3");
    op_load = 1; load_word = 8'hFF; step("R10 load forces bit 2 to 0");
    op_load = 1; load_word = 8'h10; op_addsub = 1; alu_result = 8'h00;
    alu_c7 = 1; alu_c3 = 0; op_ei = 1; op_selbank = 1; bank_in = 2'd3;
    step("R10 load overrides updates");
    op_bitop = 1; bit_in = 1; step("R11 bitop keeps Z AC");
    rst = 1; step("R1 reset after activity");
    rst = 0; step("R1 idle after reset");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule